// File: doc/BRIEF.md
# Event Annotation Window Monitor

This block is a runtime monitor for a single stream of events. Each event arrives with a timestamp, and the block gives each accepted event an index in arrival order, starting at zero. It checks one constraint between two timestamps that are a fixed number of occurrences apart. In rate mode, every event after the first must follow its predecessor by exactly `PERIOD` time units. In throughput mode, the event at index k must arrive no more than `BUDGET` time units after the event at index k-`SPAN`. In other words, any `SPAN` gaps in a row may add up to at most `BUDGET`.

The block keeps only the `SPAN`+1 newest timestamps in a circular history. It gives a verdict on an event only when both timestamps that the check needs are present. Events in the warm-up phase therefore produce no verdict. A failed check raises a one-cycle violation pulse and a fail flag that stays set. A free-running count reports how many events have been accepted.

Events enter on a valid/ready interface. The monitor never back-pressures: `ev_ready` is high in every cycle outside reset, so an event is accepted on any clock edge where `ev_valid` is high and reset is low. The mode pin should be changed only while reset is held.

Top module: `event_window_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `viol_o` and `fail_o` are 0 and `occ_count_o` is 0.
- R2: `occ_count_o` rises by exactly one for each accepted event (`ev_valid` and `ev_ready` high at a clock edge) and holds its value otherwise.
- R3: With `mode_i` = 0 (rate), an accepted event with index k ≥ 1 is a violation when its timestamp minus the timestamp of event k-1 is not exactly `PERIOD` (default 10).
- R4: In rate mode the event with index 0 never produces a violation.
- R5: With `mode_i` = 1 (throughput), an accepted event with index k ≥ `SPAN` (default 100) is a violation when its timestamp minus that of event k-`SPAN` exceeds `BUDGET` (default 1001). A difference equal to `BUDGET` passes.
- R6: In throughput mode the events with index 0 to `SPAN`-1 never produce a violation, whatever their timestamps.
- R7: `viol_o` is high for exactly the one cycle after the clock edge that accepted a violating event, and it is low in any cycle that does not follow an accepting edge.
- R8: `fail_o` becomes 1 together with the first violation pulse. After that it stays 1, through later passing events and idle cycles, until a reset clears it.
- R9: Verdicts stay correct over arbitrarily long runs. The history holds only the `SPAN`+1 newest timestamps, and the oldest entry is overwritten once the history is full.
- R10: `ev_ready` is 0 while reset is asserted and 1 in every other cycle.
- R11: Differences are formed one bit wider than the timestamps and treated as signed. A timestamp that is lower than its reference gives a negative difference, not a wrapped large one. Such an event fails in rate mode and passes in throughput mode. Equal timestamps, as simultaneous events carry, give a difference of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = rate check, 1 = throughput check |
| ev_valid | input | 1 | An event is presented |
| ev_ready | output | 1 | Monitor accepts events (high outside reset) |
| ev_ts | input | TS_W | Timestamp of the presented event |
| viol_o | output | 1 | One-cycle pulse after a violating event is accepted |
| fail_o | output | 1 | Sticky flag: a violation has occurred since reset |
| occ_count_o | output | CNT_W | Number of events accepted since reset |

## Verification
Rate mode is driven with exact spacings, with spacings one unit short or long, with repeated timestamps and with timestamps that step backwards. These patterns show whether the exact-equality test is right and whether the difference is treated as signed. Throughput mode is driven with a warm-up window that contains a large jump, and then with windows whose total is exactly `BUDGET` and `BUDGET`+1. This exposes verdicts given too early and an off-by-one in the bound. Long seeded random runs in both modes, with spacings near the limit and idle gaps in between, wrap the circular history many times. They show whether the right stored entry is compared and whether idle cycles ever disturb the pulse or the count.

// File: rtl/ewm_pkg.sv
package ewm_pkg;
  typedef enum logic {
    MODE_RATE = 1'b0,
    MODE_THRU = 1'b1
  } ewm_mode_e;
endpackage

// File: rtl/ewm_history.sv
// Circular store of the DEPTH newest timestamps. Reads return the entry one
// behind the next write slot (newest) and the entry DEPTH-1 behind it (oldest).
module ewm_history #(
  parameter int TS_W  = 32,
  parameter int DEPTH = 101
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [TS_W-1:0] wr_data,
  output logic [TS_W-1:0] newest_o,
  output logic [TS_W-1:0] oldest_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr;
  logic [AW-1:0] newest_idx;
  logic [AW-1:0] oldest_idx;
  logic [TS_W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
    end else if (wr_en) begin
      wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [TS_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (wptr == AW'(g))) begin
        q <= wr_data;
      end
    end
    assign slot_q[g] = q;
  end

  always_comb begin
    newest_idx = (wptr == '0) ? LAST : wptr - 1'b1;
    oldest_idx = (wptr == LAST) ? '0 : wptr + 1'b1;
  end

  assign newest_o = slot_q[newest_idx];
  assign oldest_o = slot_q[oldest_idx];
endmodule

// File: rtl/ewm_fill.sv
// Saturating count of events seen so far, capped at LIMIT.
module ewm_fill #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  output logic have_prev_o,
  output logic have_span_o
);
  localparam int FW = $clog2(LIMIT + 1);
  localparam logic [FW-1:0] CAP = FW'(LIMIT);

  logic [FW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (inc && (fill_q != CAP)) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  assign have_prev_o = (fill_q != '0);
  assign have_span_o = (fill_q == CAP);
endmodule

// File: rtl/ewm_judge.sv
// Forms the widened signed difference, applies the active rule and registers
// the verdict as a pulse plus a sticky flag.
module ewm_judge
  import ewm_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int PERIOD = 10,
  parameter int BUDGET = 1001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  ewm_mode_e       mode,
  input  logic [TS_W-1:0] ts,
  input  logic [TS_W-1:0] newest,
  input  logic [TS_W-1:0] oldest,
  input  logic            have_prev,
  input  logic            have_span,
  output logic            viol_o,
  output logic            fail_o
);
  localparam int DW = TS_W + 1;
  localparam logic signed [DW-1:0] PERIOD_S = DW'(PERIOD);
  localparam logic signed [DW-1:0] BUDGET_S = DW'(BUDGET);

  logic [TS_W-1:0]        ref_ts;
  logic signed [DW-1:0]   diff;
  logic                   bad_rate;
  logic                   bad_thru;
  logic                   bad;

  always_comb begin
    ref_ts   = (mode == MODE_RATE) ? newest : oldest;
    diff     = $signed({1'b0, ts}) - $signed({1'b0, ref_ts});
    bad_rate = have_prev && (diff != PERIOD_S);
    bad_thru = have_span && (diff > BUDGET_S);
    bad      = accept && ((mode == MODE_RATE) ? bad_rate : bad_thru);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      viol_o <= bad;
      fail_o <= fail_o | bad;
    end
  end
endmodule

// File: rtl/event_window_monitor.sv
module event_window_monitor
  import ewm_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int CNT_W  = 32,
  parameter int SPAN   = 100,
  parameter int PERIOD = 10,
  parameter int BUDGET = 1001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [TS_W-1:0]  ev_ts,
  output logic             viol_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] occ_count_o
);
  localparam int DEPTH = SPAN + 1;

  ewm_mode_e       mode;
  logic            accept;
  logic [TS_W-1:0] newest_ts;
  logic [TS_W-1:0] oldest_ts;
  logic            have_prev;
  logic            have_span;
  logic [CNT_W-1:0] count_q;

  assign mode     = ewm_mode_e'(mode_i);
  assign ev_ready = !rst;
  assign accept   = ev_valid && ev_ready;

  ewm_history #(.TS_W(TS_W), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept),
    .wr_data  (ev_ts),
    .newest_o (newest_ts),
    .oldest_o (oldest_ts)
  );

  ewm_fill #(.LIMIT(SPAN)) u_fill (
    .clk         (clk),
    .rst         (rst),
    .inc         (accept),
    .have_prev_o (have_prev),
    .have_span_o (have_span)
  );

  ewm_judge #(.TS_W(TS_W), .PERIOD(PERIOD), .BUDGET(BUDGET)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .mode      (mode),
    .ts        (ev_ts),
    .newest    (newest_ts),
    .oldest    (oldest_ts),
    .have_prev (have_prev),
    .have_span (have_span),
    .viol_o    (viol_o),
    .fail_o    (fail_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (accept) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign occ_count_o = count_q;
endmodule

// File: rtl/ewm_checker.sv
module ewm_checker #(
  parameter int CNT_W = 32,
  parameter int SPAN  = 100
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_i,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic             viol_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] occ_count_o
);
  logic acc;
  assign acc = ev_valid && ev_ready;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!viol_o && !fail_o && (occ_count_o == '0)));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    acc |=> (occ_count_o == CNT_W'($past(occ_count_o) + 1'b1)));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(occ_count_o));

  p_first_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && !mode_i && (occ_count_o == '0)) |=> !viol_o);

  p_warmup_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && mode_i && (occ_count_o < CNT_W'(SPAN))) |=> !viol_o);

  p_pulse_needs_accept_r7: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !viol_o);

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> fail_o);

  p_pulse_sets_fail_r8: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> fail_o);

  p_ready_r10: assert property (@(posedge clk) ev_ready == !rst);
endmodule

bind event_window_monitor ewm_checker #(.CNT_W(CNT_W), .SPAN(SPAN)) u_ewm_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .ev_valid    (ev_valid),
  .ev_ready    (ev_ready),
  .viol_o      (viol_o),
  .fail_o      (fail_o),
  .occ_count_o (occ_count_o)
);

// File: tb/event_window_monitor_bench.sv
`timescale 1ns/1ps
module event_window_monitor_bench;
  localparam int TS_W   = 32;
  localparam int CNT_W  = 32;
  localparam int SPAN   = 100;
  localparam int PERIOD = 10;
  localparam int BUDGET = 1001;
  localparam int LOG_N  = 2048;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_i = 1'b0;
  logic             ev_valid = 1'b0;
  logic             ev_ready;
  logic [TS_W-1:0]  ev_ts = '0;
  logic             viol_o;
  logic             fail_o;
  logic [CNT_W-1:0] occ_count_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [TS_W-1:0] ts_log [LOG_N];
  int  k_idx = 0;
  longint exp_count = 0;
  bit  exp_fail = 1'b0;

  always #2 clk = ~clk;

  event_window_monitor #(
    .TS_W(TS_W), .CNT_W(CNT_W), .SPAN(SPAN), .PERIOD(PERIOD), .BUDGET(BUDGET)
  ) u_event_window_monitor (
    .clk(clk), .rst(rst), .mode_i(mode_i), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_ts(ev_ts), .viol_o(viol_o), .fail_o(fail_o),
    .occ_count_o(occ_count_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc == 150000) begin
      failures++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (event %0d)", tag, act, exp, k_idx);
    end
  endtask

  function automatic bit model_viol(input bit thru, input int k);
    longint d;
    if (!thru) begin
      if (k < 1) return 1'b0;
      d = longint'(ts_log[k]) - longint'(ts_log[k-1]);
      return d != PERIOD;
    end
    if (k < SPAN) return 1'b0;
    d = longint'(ts_log[k]) - longint'(ts_log[k-SPAN]);
    return d > BUDGET;
  endfunction

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst = 1'b1; mode_i = m; ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", ev_ready, 0);
    chk("R1", viol_o, 0);
    chk("R1", fail_o, 0);
    rst = 1'b0;
    #1;
    chk("R10", ev_ready, 1);
    chk("R1", viol_o, 0);
    chk("R1", fail_o, 0);
    chk("R1", occ_count_o, 0);
    exp_count = 0; exp_fail = 1'b0; k_idx = 0;
    @(negedge clk);
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic send(input logic [TS_W-1:0] ts, input string tag_in);
    bit e;
    string tag;
    ts_log[k_idx] = ts;
    e = model_viol(mode_i, k_idx);
    if (tag_in != "") tag = tag_in;
    else if (!mode_i) tag = (k_idx == 0) ? "R4" : "R3";
    else if (k_idx < SPAN) tag = "R6";
    else tag = "R9";
    ev_valid = 1'b1; ev_ts = ts;
    @(negedge clk);
    ev_valid = 1'b0;
    exp_count++;
    exp_fail = exp_fail | e;
    chk(tag, viol_o, e);
    chk("R8", fail_o, exp_fail);
    chk("R2", occ_count_o, exp_count);
    k_idx++;
  endtask

  task automatic idle(input int n);
    ev_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R7", viol_o, 0);
      chk("R2", occ_count_o, exp_count);
      chk("R8", fail_o, exp_fail);
    end
  endtask

  initial begin
    logic [TS_W-1:0] t;
    void'($urandom(32'd20240611));

    // Rate mode, directed corners
    do_reset(1'b0);
    send(32'd5,  "R4");
    send(32'd15, "R3");
    send(32'd25, "R3");
    idle(2);
    send(32'd36, "R3");     // one long: violation
    chk("R7", viol_o, 1);
    idle(1);                // pulse gone after one cycle
    send(32'd46, "R3");     // fail stays set
    send(32'd46, "R11");    // equal timestamps
    send(32'd40, "R11");    // backwards step
    send(32'd50, "R3");
    idle(3);
    chk("R8", fail_o, 1);

    // Reset clears the sticky flag; rate random run
    do_reset(1'b0);
    chk("R8", fail_o, 0);
    t = 32'd1000;
    for (int i = 0; i < 400; i++) begin
      int g;
      g = ($urandom % 8 == 0) ? (($urandom % 2 == 1) ? 9 : 11) : PERIOD;
      t = t + TS_W'(g);
      send(t, "");
      if ($urandom % 6 == 0) idle(1 + int'($urandom % 3));
    end

    // Throughput directed: warm-up with a jump, then boundary windows
    do_reset(1'b1);
    for (int i = 0; i < SPAN - 1; i++) send(TS_W'(i * 10), "R6");
    send(32'd5000, "R6");   // warm-up jump, no verdict
    send(32'd1001, "R5");   // ref 0: diff = BUDGET passes
    send(32'd1012, "R5");   // ref 10: diff = BUDGET+1 fails
    send(32'd1000, "R5");   // ref 20: passes
    send(32'd20,   "R11");  // ref 30: negative diff passes
    idle(2);

    // Throughput random runs, history wraps many times
    do_reset(1'b1);
    t = 32'd77;
    for (int i = 0; i < 700; i++) begin
      t = t + TS_W'($urandom % 21);
      send(t, "");
      if ($urandom % 10 == 0) idle(1);
    end

    // Rate mode with a counter near the top of the timestamp range
    do_reset(1'b0);
    send(32'hFFFF_FFF0, "R11");
    send(32'hFFFF_FFFA, "R11");
    send(32'h0000_0004, "R11"); // wrapped value: negative difference fails

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule